// File: doc/BRIEF.md
# Register Write Protection Unit

This block guards the write path from a simple peripheral register bus into a bank of configuration registers split into six groups. Each group carries two independent locks: a software lock, which control inputs can set and clear, and a hardware lock, which once set stays set until reset. A bus write whose address falls inside a locked group is held back, and the matching group write enable stays low. A write to an unlocked group, or to an address outside every group, passes through as a one-hot write enable.

Every blocked write is logged in a read-only 32-bit status word. The word holds a sticky violation flag and the address offset of the first blocked write since the word was last read. Reading the word at its fixed offset returns its contents and then clears the flag and the stored offset. Address ranges for the groups come from a fixed parameter table.

Top module: `wr_guard`

## Requirements
- R1: After reset the status word reads 0x00000000 and every group accepts writes.
- R2: A bus write to an address inside the range of an unlocked group g drives grp_wr_en to (1<<g) in the same cycle, with no other bit set.
- R3: A bus write to a group whose software lock or hardware lock is set leaves grp_wr_en at zero.
- R4: sw_lock_set[g] sets and sw_lock_clr[g] clears the software lock of group g from the next cycle; if both are high together, set wins. Status bits 5:0 show the software locks of groups 5..0.
- R5: hw_lock_set[g] sets the hardware lock of group g. Only reset clears it, and sw_lock_clr has no effect on it. Status bits 13:8 show the hardware locks of groups 5..0.
- R6: Writes to addresses outside every group range, including the status offset 0xE8, are never blocked and never raise the violation flag.
- R7: A blocked write sets status bit 7 from the next cycle, and status bits 31:16 then hold the 16-bit write address.
- R8: While the flag is set, later blocked writes keep the flag set and leave the stored address unchanged.
- R9: A status read (bus_rd high with bus_raddr = 0xE8) returns the word in the same cycle. From the next cycle the flag and the address field read zero.
- R10: A blocked write in the same cycle as a status read: the read returns the old word. Afterwards the flag is set and the address field holds that write's address.
- R11: Status bits 6, 15 and 14 always read zero. bus_rdata is zero in any cycle without a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 16 | Write address offset |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 16 | Read address offset |
| sw_lock_set | input | 6 | Per-group software lock set |
| sw_lock_clr | input | 6 | Per-group software lock clear |
| hw_lock_set | input | 6 | Per-group hardware lock set |
| grp_wr_en | output | 6 | Per-group write enable toward the registers |
| bus_rdata | output | 32 | Status word during a status read, else zero |

## Verification
The hardest situation to reach is a blocked write in the very cycle that the status word is read, because it needs both the read and the write side of the bus active at once. The separate read and write address ports let the bench issue a status read and a write into a locked group in one cycle, after an earlier violation has already filled the log. It then checks that the returned word still shows the older address and that the next read shows the newer one with the flag still set.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;
  localparam int NGRP = 6;
  localparam int AW   = 16;
  localparam int DW   = 32;

  // status layout: [31:16] offset, [13:8] hw locks, [7] flag, [5:0] sw locks
  function automatic logic [DW-1:0] pack_status(
    input logic [NGRP-1:0] sw,
    input logic [NGRP-1:0] hw,
    input logic            flag,
    input logic [AW-1:0]   src
  );
    logic [DW-1:0] w;
    w        = '0;
    w[5:0]   = sw;
    w[7]     = flag;
    w[13:8]  = hw;
    w[31:16] = src;
    return w;
  endfunction

  function automatic logic in_range(
    input logic [AW-1:0] a,
    input logic [AW-1:0] lo,
    input logic [AW-1:0] hi
  );
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/wr_guard_decode.sv
module wr_guard_decode
  import wr_guard_pkg::*;
#(
  parameter int NG = NGRP,
  parameter logic [NG*AW-1:0] LO_TAB = {16'h00A0, 16'h0080, 16'h0060,
                                        16'h0040, 16'h0020, 16'h0000},
  parameter logic [NG*AW-1:0] HI_TAB = {16'h00BF, 16'h009F, 16'h007F,
                                        16'h005F, 16'h003F, 16'h001F}
) (
  input  logic [AW-1:0] addr,
  output logic [NG-1:0] hit
);
  for (genvar g = 0; g < NG; g++) begin : g_rng
    localparam logic [AW-1:0] LO = LO_TAB[g*AW +: AW];
    localparam logic [AW-1:0] HI = HI_TAB[g*AW +: AW];
    assign hit[g] = in_range(addr, LO, HI);
  end
endmodule

// File: rtl/wr_guard_locks.sv
module wr_guard_locks
  import wr_guard_pkg::*;
#(
  parameter int NG = NGRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] sw_set,
  input  logic [NG-1:0] sw_clr,
  input  logic [NG-1:0] hw_set,
  output logic [NG-1:0] sw_q,
  output logic [NG-1:0] hw_q
);
  for (genvar g = 0; g < NG; g++) begin : g_lk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sw_q[g] <= 1'b0;
        hw_q[g] <= 1'b0;
      end else begin
        if (sw_set[g])      sw_q[g] <= 1'b1;
        else if (sw_clr[g]) sw_q[g] <= 1'b0;
        if (hw_set[g])      hw_q[g] <= 1'b1;
      end
    end
  end

  p_hw_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_q != '0) |=> ((hw_q & $past(hw_q)) == $past(hw_q)));
  p_sw_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((sw_q & $past(sw_set)) == $past(sw_set)));
endmodule

// File: rtl/wr_guard_log.sv
module wr_guard_log
  import wr_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol_evt,
  input  logic [AW-1:0] viol_addr,
  input  logic          rd_clr,
  output logic          flag_q,
  output logic [AW-1:0] src_q
);
  logic          flag_d;
  logic [AW-1:0] src_d;
  logic          capture;

  // capture when log is empty or being emptied this cycle
  assign capture = viol_evt && (!flag_q || rd_clr);

  always_comb begin
    flag_d = flag_q;
    src_d  = src_q;
    if (rd_clr) begin
      flag_d = 1'b0;
      src_d  = '0;
    end
    if (capture) begin
      flag_d = 1'b1;
      src_d  = viol_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      src_q  <= '0;
    end else begin
      flag_q <= flag_d;
      src_q  <= src_d;
    end
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_evt |=> flag_q);
  p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_clr) |=> $stable(src_q));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !viol_evt) |=> (!flag_q && src_q == '0));
  p_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && viol_evt) |=> (flag_q && src_q == $past(viol_addr)));
endmodule

// File: rtl/wr_guard.sv
module wr_guard
  import wr_guard_pkg::*;
#(
  parameter logic [AW-1:0] STAT_OFS = 16'h00E8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_waddr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_raddr,
  input  logic [NGRP-1:0] sw_lock_set,
  input  logic [NGRP-1:0] sw_lock_clr,
  input  logic [NGRP-1:0] hw_lock_set,
  output logic [NGRP-1:0] grp_wr_en,
  output logic [DW-1:0]   bus_rdata
);
  logic [NGRP-1:0] hit, sw_q, hw_q, locked, wr_hit, blk;
  logic            viol_evt, stat_rd, flag_q;
  logic [AW-1:0]   src_q;

  wr_guard_decode #(.NG(NGRP)) u_dec (.addr(bus_waddr), .hit(hit));

  wr_guard_locks #(.NG(NGRP)) u_lk (
    .clk(clk), .rst_n(rst_n),
    .sw_set(sw_lock_set), .sw_clr(sw_lock_clr), .hw_set(hw_lock_set),
    .sw_q(sw_q), .hw_q(hw_q)
  );

  assign locked    = sw_q | hw_q;
  assign wr_hit    = {NGRP{bus_wr}} & hit;
  assign grp_wr_en = wr_hit & ~locked;
  assign blk       = wr_hit & locked;
  assign viol_evt  = |blk;
  assign stat_rd   = bus_rd && (bus_raddr == STAT_OFS);

  wr_guard_log u_log (
    .clk(clk), .rst_n(rst_n),
    .viol_evt(viol_evt), .viol_addr(bus_waddr), .rd_clr(stat_rd),
    .flag_q(flag_q), .src_q(src_q)
  );

  assign bus_rdata = stat_rd ? pack_status(sw_q, hw_q, flag_q, src_q) : '0;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_wr_en));
  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_wr_en & (sw_q | hw_q)) == '0);
  p_no_viol_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit == '0) |-> !viol_evt);
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[6] == 1'b0) && (bus_rdata[15:14] == 2'b00));
endmodule

// File: tb/wr_guard_tb.sv
module wr_guard_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_waddr = '0, bus_raddr = '0;
  logic [5:0]  sw_lock_set = '0, sw_lock_clr = '0, hw_lock_set = '0;
  logic [5:0]  grp_wr_en;
  logic [31:0] bus_rdata;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  wr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_rd(bus_rd), .bus_raddr(bus_raddr), .sw_lock_set(sw_lock_set),
    .sw_lock_clr(sw_lock_clr), .hw_lock_set(hw_lock_set),
    .grp_wr_en(grp_wr_en), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] word(input logic [5:0] sw, input logic [5:0] hw,
                                       input logic f, input logic [15:0] a);
    return {a, 2'b00, hw, f, 1'b0, sw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, settle, leave outputs to be sampled
  task automatic drive(input logic wr, input logic [15:0] wa, input logic rd,
                       input logic [15:0] ra, input logic [5:0] ss,
                       input logic [5:0] sc, input logic [5:0] hs);
    @(negedge clk);
    bus_wr = wr; bus_waddr = wa; bus_rd = rd; bus_raddr = ra;
    sw_lock_set = ss; sw_lock_clr = sc; hw_lock_set = hs;
    #1;
  endtask

  task automatic idle();
    drive(0, 16'h0, 0, 16'h0, 6'h0, 6'h0, 6'h0);
  endtask

  task automatic rd_stat(output logic [31:0] w);
    drive(0, 16'h0, 1, 16'h00E8, 6'h0, 6'h0, 6'h0);
    w = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] w;
    idle();
    chk("R1 rdata idle", bus_rdata, 32'h0);
    rd_stat(w);
    chk("R1 status after reset", w, 32'h0);
    drive(0, 16'h0, 1, 16'h00E4, 6'h0, 6'h0, 6'h0);
    chk("R11 non-status read", bus_rdata, 32'h0);
  endtask

  task automatic t_open();
    drive(1, 16'h0024, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R2 group1 write", {26'h0, grp_wr_en}, 32'h02);
    drive(1, 16'h00A4, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R2 group5 write", {26'h0, grp_wr_en}, 32'h20);
    drive(1, 16'h0000, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R2 group0 low edge", {26'h0, grp_wr_en}, 32'h01);
  endtask

  task automatic t_sw();
    logic [31:0] w;
    drive(0, 16'h0, 0, 16'h0, 6'h02, 6'h0, 6'h0);
    drive(1, 16'h0024, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R3 sw lock blocks", {26'h0, grp_wr_en}, 32'h0);
    rd_stat(w);
    chk("R7 flag and addr", w, word(6'h02, 6'h0, 1'b1, 16'h0024));
    rd_stat(w);
    chk("R9 cleared after read", w, word(6'h02, 6'h0, 1'b0, 16'h0));
    drive(0, 16'h0, 0, 16'h0, 6'h08, 6'h0A, 6'h0);
    rd_stat(w);
    chk("R4 clear g1, set wins g3", w, word(6'h08, 6'h0, 1'b0, 16'h0));
    drive(1, 16'h0024, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R4 g1 unlocked again", {26'h0, grp_wr_en}, 32'h02);
    drive(0, 16'h0, 0, 16'h0, 6'h0, 6'h08, 6'h0);
  endtask

  task automatic t_hw();
    logic [31:0] w;
    drive(0, 16'h0, 0, 16'h0, 6'h0, 6'h0, 6'h01);
    drive(0, 16'h0, 0, 16'h0, 6'h0, 6'h3F, 6'h0);
    drive(1, 16'h0004, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R3 hw lock blocks", {26'h0, grp_wr_en}, 32'h0);
    rd_stat(w);
    chk("R5 hw survives sw clear", w, word(6'h0, 6'h01, 1'b1, 16'h0004));
  endtask

  task automatic t_first();
    logic [31:0] w;
    drive(1, 16'h0008, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    drive(1, 16'h0010, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    rd_stat(w);
    chk("R8 first addr kept", w, word(6'h0, 6'h01, 1'b1, 16'h0008));
  endtask

  task automatic t_outside();
    logic [31:0] w;
    drive(1, 16'h00C4, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R6 outside no enable", {26'h0, grp_wr_en}, 32'h0);
    drive(1, 16'h00E8, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    rd_stat(w);
    chk("R6 outside no flag", w, word(6'h0, 6'h01, 1'b0, 16'h0));
    chk("R11 reserved bits", {16'h0, w[15:14], 7'h0, w[6], 6'h0}, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] w;
    drive(1, 16'h000C, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    drive(1, 16'h0014, 1, 16'h00E8, 6'h0, 6'h0, 6'h0);
    chk("R10 read returns old", bus_rdata, word(6'h0, 6'h01, 1'b1, 16'h000C));
    rd_stat(w);
    chk("R10 new event kept", w, word(6'h0, 6'h01, 1'b1, 16'h0014));
    rd_stat(w);
    chk("R9 empty after second read", w, word(6'h0, 6'h01, 1'b0, 16'h0));
  endtask

  task automatic t_rst_hw();
    logic [31:0] w;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_stat(w);
    chk("R5 reset clears hw lock", w, 32'h0);
    drive(1, 16'h0004, 0, 16'h0, 6'h0, 6'h0, 6'h0);
    chk("R1 group0 open after reset", {26'h0, grp_wr_en}, 32'h01);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_open();
    t_sw();
    t_hw();
    t_first();
    t_outside();
    t_race();
    t_rst_hw();
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule